// File: doc/BRIEF.md
# Register Rename Unit with Free-Tag Queue

This block turns architectural register numbers into physical register tags for an out-of-order core. It holds a map table with one physical tag per architectural register, a queue of physical tags that nothing is using, and a snapshot of the map table used for recovery. In each cycle it can rename one instruction. It looks up the two source registers. If the instruction writes a register, it takes a fresh tag from the head of the queue for the destination and reports the tag that the destination held before.

The tag that the destination held before is not freed at once. The caller keeps it and hands it back through the release port once no instruction in flight can still read it. A tag that has left the map table is therefore still reserved until it is released.

For recovery, a snapshot command copies the whole map table and the queue's read position. A restore command puts both back in a single cycle. Any tags handed out after the snapshot then become available again, in the order they were originally handed out.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The queue holds tags ARCH_REGS to PHYS_REGS-1 in ascending order, so the first tag handed out is 32 with the default parameters, and `ren_ready` is high.
- R2: `src_a_tag` and `src_b_tag` show the current mapping of `ren_src_a` and `ren_src_b` in the same cycle, combinationally.
- R3: An accepted rename with `ren_writes`=1 hands out the queue-head tag on `dst_new_tag`. From the next cycle on, the destination maps to that tag, and the queue advances by one.
- R4: `dst_prev_tag` shows the destination's mapping from before the update. A source that equals the destination reads that old mapping.
- R5: An accepted rename with `ren_writes`=0 takes no tag and leaves the map unchanged.
- R6: When the queue is empty, `ren_ready` is low. A request in that cycle changes neither the map nor the queue.
- R7: `free_valid` appends `free_tag` at the tail of the queue. Tags are handed out strictly first in, first out.
- R8: `snap_take` records the map table and the queue read position as they stand at the start of that cycle. `snap_restore` brings both back, so the first tag handed out after the snapshot is handed out again next.
- R9: While `snap_restore` is high, `ren_ready` is low and a rename request is ignored.
- R10: A release and a rename in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_writes | input | 1 | Instruction writes a destination register |
| ren_src_a | input | 5 | First source architectural register |
| ren_src_b | input | 5 | Second source architectural register |
| ren_dst | input | 5 | Destination architectural register |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| src_a_tag | output | 6 | Physical tag of first source |
| src_b_tag | output | 6 | Physical tag of second source |
| dst_new_tag | output | 6 | Tag allocated for the destination (queue head) |
| dst_prev_tag | output | 6 | Destination's previous tag |
| free_valid | input | 1 | Release a physical tag |
| free_tag | input | 6 | Tag being released |
| snap_take | input | 1 | Record the map table and queue position |
| snap_restore | input | 1 | Restore the recorded state |

## Verification
The assertions rely on the caller keeping the queue and the map disjoint. A tag may be released only after it came out on `dst_prev_tag`, only once, and never while it is mapped. Under that condition a freshly allocated tag always differs from the tag it replaces, and the queue never holds more than PHYS_REGS-ARCH_REGS tags. The stimulus releases only tags it collected from `dst_prev_tag`. It restores only to a snapshot after which no tags were released, so the restored queue region has not been overwritten.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_REGS_DEF = 32;
  localparam int PHYS_REGS_DEF = 64;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_d_idx,
  output logic [TW-1:0] rd_a_tag,
  output logic [TW-1:0] rd_b_tag,
  output logic [TW-1:0] rd_d_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic          save,
  input  logic          load
);
  logic [TW-1:0] map_q  [ARCH_REGS];
  logic [TW-1:0] map_d  [ARCH_REGS];
  logic [TW-1:0] snap_q [ARCH_REGS];
  logic [TW-1:0] snap_d [ARCH_REGS];

  assign rd_a_tag = map_q[rd_a_idx];
  assign rd_b_tag = map_q[rd_b_idx];
  assign rd_d_tag = map_q[rd_d_idx];

  always_comb begin
    for (int i = 0; i < ARCH_REGS; i++) begin
      map_d[i]  = map_q[i];
      snap_d[i] = save ? map_q[i] : snap_q[i];
    end
    if (load) begin
      for (int i = 0; i < ARCH_REGS; i++) map_d[i] = snap_q[i];
    end else if (wr_en) begin
      map_d[wr_idx] = wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        map_q[i]  <= TW'(i);
        snap_q[i] <= TW'(i);
      end
    end else begin
      if (load || wr_en) begin
        for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= map_d[i];
      end
      if (save) begin
        for (int i = 0; i < ARCH_REGS; i++) snap_q[i] <= snap_d[i];
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load) |=> map_q[$past(wr_idx)] == $past(wr_tag)); // R3
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int DEPTH = 32,
  parameter int BASE  = 32,
  parameter int TW    = 6,
  localparam int CW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [TW-1:0] head_tag,
  output logic          empty,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          save,
  input  logic          load
);
  logic [TW-1:0] mem_q [DEPTH];
  logic [CW:0]   head_q, head_d;
  logic [CW:0]   tail_q, tail_d;
  logic [CW:0]   ckpt_q, ckpt_d;
  logic [CW:0]   count;

  assign count    = tail_q - head_q;
  assign empty    = (count == '0);
  assign head_tag = mem_q[head_q[CW-1:0]];

  always_comb begin
    head_d = head_q;
    if (load)     head_d = ckpt_q;
    else if (pop) head_d = head_q + 1'b1;
    tail_d = push ? tail_q + 1'b1 : tail_q;
    ckpt_d = save ? head_q : ckpt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= TW'(BASE + i);
      head_q <= '0;
      tail_q <= (CW+1)'(DEPTH);
      ckpt_q <= '0;
    end else begin
      if (push) mem_q[tail_q[CW-1:0]] <= push_tag;
      if (load || pop) head_q <= head_d;
      if (push) tail_q <= tail_d;
      if (save) ckpt_q <= ckpt_d;
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != (CW+1)'(DEPTH)) || pop); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !load) |=> count == (CW+1)'($past(count) + 1'b1)); // R7
  AST_RESTORE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !save) |=> head_q == $past(ckpt_q)); // R8
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit #(
  parameter int ARCH_REGS = rn_pkg::ARCH_REGS_DEF,
  parameter int PHYS_REGS = rn_pkg::PHYS_REGS_DEF,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(PHYS_REGS),
  localparam int FREE_DEPTH = PHYS_REGS - ARCH_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic          ren_writes,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic [TW-1:0] src_a_tag,
  output logic [TW-1:0] src_b_tag,
  output logic [TW-1:0] dst_new_tag,
  output logic [TW-1:0] dst_prev_tag,
  input  logic          free_valid,
  input  logic [TW-1:0] free_tag,
  input  logic          snap_take,
  input  logic          snap_restore
);
  logic q_empty;
  logic alloc;

  assign ren_ready = !q_empty && !snap_restore;
  assign alloc     = ren_valid && ren_ready && ren_writes;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (ren_src_a),
    .rd_b_idx (ren_src_b),
    .rd_d_idx (ren_dst),
    .rd_a_tag (src_a_tag),
    .rd_b_tag (src_b_tag),
    .rd_d_tag (dst_prev_tag),
    .wr_en    (alloc),
    .wr_idx   (ren_dst),
    .wr_tag   (dst_new_tag),
    .save     (snap_take),
    .load     (snap_restore)
  );

  rn_free_list #(.DEPTH(FREE_DEPTH), .BASE(ARCH_REGS), .TW(TW)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc),
    .head_tag (dst_new_tag),
    .empty    (q_empty),
    .push     (free_valid),
    .push_tag (free_tag),
    .save     (snap_take),
    .load     (snap_restore)
  );

  AST_NEW_NOT_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> dst_new_tag != dst_prev_tag); // R4
  AST_SELF_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_src_a == ren_dst) |-> src_a_tag == dst_prev_tag); // R4
endmodule

// File: tb/tb_reg_rename_unit.sv
module tb_reg_rename_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, ren_writes;
  logic [4:0] ren_src_a, ren_src_b, ren_dst;
  logic       ren_ready;
  logic [5:0] src_a_tag, src_b_tag, dst_new_tag, dst_prev_tag;
  logic       free_valid;
  logic [5:0] free_tag;
  logic       snap_take, snap_restore;
  int errs = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  reg_rename_unit dut (.*);

  // {writes, src_a, src_b, dst, exp_a, exp_b, exp_new, exp_prev}
  localparam logic [39:0] VEC [6] = '{
    {1'b1, 5'd1,  5'd2,  5'd3,  6'd1,  6'd2,  6'd32, 6'd3 },
    {1'b1, 5'd3,  5'd3,  5'd3,  6'd32, 6'd32, 6'd33, 6'd32},
    {1'b0, 5'd3,  5'd4,  5'd5,  6'd33, 6'd4,  6'd34, 6'd5 },
    {1'b1, 5'd5,  5'd0,  5'd5,  6'd5,  6'd0,  6'd34, 6'd5 },
    {1'b1, 5'd5,  5'd31, 5'd31, 6'd34, 6'd31, 6'd35, 6'd31},
    {1'b0, 5'd31, 5'd3,  5'd0,  6'd35, 6'd33, 6'd36, 6'd0 }
  };
  localparam logic [5:0] REL_ORDER [4] = '{6'd3, 6'd32, 6'd5, 6'd31};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [4:0] a,
                       input logic [4:0] b, input logic [4:0] d,
                       input logic rv, input logic [5:0] rt,
                       input logic sv, input logic ld);
    @(negedge clk);
    ren_valid = v; ren_writes = w; ren_src_a = a; ren_src_b = b; ren_dst = d;
    free_valid = rv; free_tag = rt; snap_take = sv; snap_restore = ld;
    #5;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 5'd7, 5'd10, 5'd0, 0, 6'd0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    drive(0, 0, 5'd7, 5'd10, 5'd0, 0, 6'd0, 0, 0);
    chk("R1 src map", src_a_tag, 7);
    chk("R1 src map b", src_b_tag, 10);
    chk("R1 ready", ren_ready, 1);
    chk("R1 first free", dst_new_tag, 32);

    // R2 R3 R4 R5 vector walk
    for (int k = 0; k < 6; k++) begin
      drive(1, VEC[k][39], VEC[k][38:34], VEC[k][33:29], VEC[k][28:24], 0, 6'd0, 0, 0);
      chk("R2 src a", src_a_tag, VEC[k][23:18]);
      chk("R2 src b", src_b_tag, VEC[k][17:12]);
      chk("R3/R5 new", dst_new_tag, VEC[k][11:6]);
      chk("R4 prev", dst_prev_tag, VEC[k][5:0]);
    end

    // R10 release alongside rename
    drive(1, 1, 5'd1, 5'd0, 5'd1, 1, 6'd3, 0, 0);
    chk("R10 new", dst_new_tag, 36);
    chk("R10 prev", dst_prev_tag, 1);
    drive(0, 0, 5'd1, 5'd0, 5'd1, 1, 6'd32, 0, 0);
    chk("R10 map updated", src_a_tag, 36);
    drive(0, 0, 5'd0, 5'd0, 5'd0, 1, 6'd5, 0, 0);
    drive(0, 0, 5'd0, 5'd0, 5'd0, 1, 6'd31, 0, 0);

    // R8 snapshot then restore
    drive(0, 0, 5'd0, 5'd0, 5'd0, 0, 6'd0, 1, 0);
    drive(1, 1, 5'd1, 5'd0, 5'd1, 0, 6'd0, 0, 0);
    chk("R8 new after snap", dst_new_tag, 37);
    chk("R8 prev after snap", dst_prev_tag, 36);
    drive(1, 1, 5'd2, 5'd0, 5'd2, 0, 6'd0, 0, 0);
    chk("R8 second alloc", dst_new_tag, 38);
    drive(1, 1, 5'd7, 5'd0, 5'd7, 0, 6'd0, 0, 1);
    chk("R9 ready low on restore", ren_ready, 0);
    drive(0, 0, 5'd1, 5'd2, 5'd7, 0, 6'd0, 0, 0);
    chk("R8 map r1 restored", src_a_tag, 36);
    chk("R8 map r2 restored", src_b_tag, 2);
    chk("R8 head restored", dst_new_tag, 37);
    chk("R9 rename ignored", dst_prev_tag, 7);

    // R6 R7 drain the queue, FIFO order
    for (int k = 0; k < 31; k++) begin
      drive(1, 1, 5'd10, 5'd4, 5'd10, 0, 6'd0, 0, 0);
      chk("R7 order", dst_new_tag, (k < 27) ? 37 + k : int'(REL_ORDER[k-27]));
      if (k == 0) chk("R4 prev drain", dst_prev_tag, 10);
    end
    drive(1, 1, 5'd4, 5'd9, 5'd4, 0, 6'd0, 0, 0);
    chk("R6 ready low when empty", ren_ready, 0);
    drive(0, 0, 5'd4, 5'd10, 5'd4, 1, 6'd10, 0, 0);
    chk("R6 map unchanged", src_a_tag, 4);
    chk("R6 last alloc kept", src_b_tag, 31);
    drive(0, 0, 5'd4, 5'd0, 5'd4, 0, 6'd0, 0, 0);
    chk("R7 ready after release", ren_ready, 1);
    chk("R7 released tag at head", dst_new_tag, 10);

    // R1 reset again
    do_reset();
    drive(0, 0, 5'd10, 5'd3, 5'd0, 0, 6'd0, 0, 0);
    chk("R1 reset map", src_a_tag, 10);
    chk("R1 reset map b", src_b_tag, 3);
    chk("R1 reset head", dst_new_tag, 32);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule